// File: doc/BRIEF.md
# Peripheral ROM Window Selector

This block sits on the read path of the upper peripheral page, addresses `$C100`-`$CFFF`, and decides which ROM drives the data bus for each access. Three kinds of source compete for the range: the internal system ROM, the 256-byte basic ROM of the card in slot n (page `$Cn00`-`$CnFF`, n = 1..7), and the 2K expansion ROM of whichever card currently owns the shared window at `$C800`-`$CFFF`. The block does not hold ROM contents. It only produces select strobes, plus an idle strobe that tells the data mux to return `$FF`.

Two level inputs steer the routing. `slot_rom_en` hands the range to the cards. `slot3_int` forces page `$C3` back to internal ROM. A three-bit expansion owner register records the slot whose basic ROM was last accessed through the card path. Any access to `$CFFF` clears that owner after the access. Removing the owning card, seen as a falling bit in `card_present`, also clears it. Select outputs are combinational from the current access. Ownership changes take effect on the following clock edge.

Top module: `rom_window_sel`

## Requirements
- R1: After synchronous reset no slot owns the expansion window, so an access to `$C800` with `slot_rom_en` high asserts only `idle_ff`.
- R2: With `acc_valid` low, or with an address outside `$C100`-`$CFFF` (including `$C000`-`$C0FF`), every select output and `idle_ff` are low.
- R3: With `slot_rom_en` low, every valid access in `$C100`-`$CFFF` asserts only `int_rom_sel`, and basic-page accesses leave the expansion owner unchanged.
- R4: With `slot3_int` high, accesses to `$C300`-`$C3FF` assert only `int_rom_sel` whatever `slot_rom_en` is, and they do not change the expansion owner.
- R5: On the card path, an access to page `$Cn` (n = 1..7) with `card_present[n-1]` high asserts only `slot_sel[n-1]` (bit i stands for slot i+1).
- R6: A card-path access to page `$Cn` makes slot n the owner from the next cycle, even when `card_present[n-1]` is low. In that case the access itself asserts only `idle_ff`.
- R7: On the card path, an access to `$C800`-`$CFFF` asserts only `exp_en[k-1]` when slot k owns the window and `card_present[k-1]` is high. Otherwise it asserts only `idle_ff`.
- R8: Any valid access to `$CFFF` is still served by the current owner and clears ownership from the next cycle, whatever the flags are.
- R9: When the owner's `card_present` bit falls from one cycle to the next, ownership is cleared, and re-inserting the card does not restore it.
- R10: At most one of `int_rom_sel`, `slot_sel`, `exp_en`, `idle_ff` is asserted in any cycle, and exactly one is asserted for a valid access inside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A bus access is present this cycle |
| acc_addr | input | 16 | Access address |
| slot_rom_en | input | 1 | Route `$C100`-`$CFFF` to card ROMs |
| slot3_int | input | 1 | Force page `$C3` to internal ROM |
| card_present | input | NUM_SLOTS | Bit i high when a card sits in slot i+1 |
| int_rom_sel | output | 1 | Internal ROM drives this access |
| slot_sel | output | NUM_SLOTS | One-hot basic ROM select per slot |
| exp_en | output | NUM_SLOTS | One-hot expansion ROM select per slot |
| idle_ff | output | 1 | No ROM answers; data reads as `$FF` |

## Verification
The bench builds the block with the default of seven slots. This covers every basic page `$C1`-`$C7` and every owner code 1 to 7, so the page-3 override, empty-slot ownership and removal of a high-numbered owner can all be reached. Random traffic with a seeded generator toggles both flags and the present mask while it concentrates addresses in the window and on `$CFFF`. Directed sequences then walk the ownership life cycle: set through an empty slot, insertion, clear by `$CFFF`, and clear by removal.

// File: rtl/romwin_pkg.sv
package romwin_pkg;

    localparam int SLOT_ID_W = 3;
    localparam logic [3:0] WIN_NIBBLE = 4'hC;
    localparam logic [11:0] CLR_OFFSET = 12'hFFF;

    typedef logic [SLOT_ID_W-1:0] slot_id_t;

    typedef enum logic [1:0] {
        RGN_NONE   = 2'd0,
        RGN_BASIC  = 2'd1,
        RGN_EXPAND = 2'd2
    } region_e;

    typedef struct packed {
        logic    hit;
        region_e region;
        logic [3:0] page;
        logic    is_clr;
    } acc_info_t;

    function automatic logic in_window(input logic [15:0] addr);
        return (addr[15:12] == WIN_NIBBLE) && (addr[11:8] != 4'h0);
    endfunction

    function automatic region_e classify(input logic [15:0] addr);
        if (!in_window(addr))
            return RGN_NONE;
        return addr[11] ? RGN_EXPAND : RGN_BASIC;
    endfunction

endpackage

// File: rtl/romwin_decode.sv
module romwin_decode
    import romwin_pkg::*;
(
    input  logic        acc_valid,
    input  logic [15:0] acc_addr,
    output acc_info_t   info
);
    region_e rgn;

    always_comb begin
        rgn         = classify(acc_addr);
        info.hit    = acc_valid && (rgn != RGN_NONE);
        info.region = acc_valid ? rgn : RGN_NONE;
        info.page   = acc_addr[11:8];
        info.is_clr = info.hit && (acc_addr[11:0] == CLR_OFFSET);
    end
endmodule

// File: rtl/romwin_route.sv
module romwin_route
    import romwin_pkg::*;
#(
    parameter int NUM_SLOTS = 7
) (
    input  acc_info_t              info,
    input  logic                   slot_rom_en,
    input  logic                   slot3_int,
    input  logic [NUM_SLOTS-1:0]   card_present,
    input  slot_id_t               owner,
    output logic                   int_rom_sel,
    output logic [NUM_SLOTS-1:0]   slot_sel,
    output logic [NUM_SLOTS-1:0]   exp_en,
    output logic                   idle_ff,
    output logic                   set_req,
    output slot_id_t               set_id
);
    localparam logic [3:0] OVR_PAGE = 4'h3;

    logic override_hit;
    logic card_path;

    always_comb begin
        override_hit = slot3_int && (info.region == RGN_BASIC) && (info.page == OVR_PAGE);
        card_path    = info.hit && slot_rom_en && !override_hit;
        int_rom_sel  = info.hit && !card_path;
        set_req      = card_path && (info.region == RGN_BASIC);
        set_id       = info.page[SLOT_ID_W-1:0];
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam slot_id_t ID = slot_id_t'(i + 1);
        assign slot_sel[i] = card_path && (info.region == RGN_BASIC)
                             && (info.page[SLOT_ID_W-1:0] == ID) && card_present[i];
        assign exp_en[i]   = card_path && (info.region == RGN_EXPAND)
                             && (owner == ID) && card_present[i];
    end

    assign idle_ff = card_path && (slot_sel == '0) && (exp_en == '0);
endmodule

// File: rtl/romwin_owner.sv
module romwin_owner
    import romwin_pkg::*;
#(
    parameter int NUM_SLOTS = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_req,
    input  slot_id_t             set_id,
    input  logic                 clr_req,
    input  logic [NUM_SLOTS-1:0] card_present,
    output slot_id_t             owner
);
    logic [NUM_SLOTS-1:0] present_q;
    logic [NUM_SLOTS-1:0] fell;
    logic                 owner_lost;
    slot_id_t             owner_q;

    assign fell = present_q & ~card_present;

    always_comb begin
        owner_lost = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (owner_q == slot_id_t'(i + 1) && fell[i])
                owner_lost = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q   <= '0;
            present_q <= '0;
        end else begin
            present_q <= card_present;
            if (set_req)
                owner_q <= set_id;
            else if (clr_req || owner_lost)
                owner_q <= '0;
        end
    end

    assign owner = owner_q;
endmodule

// File: rtl/rom_window_sel.sv
module rom_window_sel
    import romwin_pkg::*;
#(
    parameter int NUM_SLOTS = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic [15:0]          acc_addr,
    input  logic                 slot_rom_en,
    input  logic                 slot3_int,
    input  logic [NUM_SLOTS-1:0] card_present,
    output logic                 int_rom_sel,
    output logic [NUM_SLOTS-1:0] slot_sel,
    output logic [NUM_SLOTS-1:0] exp_en,
    output logic                 idle_ff
);
    acc_info_t info;
    slot_id_t  owner;
    logic      set_req;
    slot_id_t  set_id;

    romwin_decode u_decode (
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .info      (info)
    );

    romwin_route #(.NUM_SLOTS(NUM_SLOTS)) u_route (
        .info         (info),
        .slot_rom_en  (slot_rom_en),
        .slot3_int    (slot3_int),
        .card_present (card_present),
        .owner        (owner),
        .int_rom_sel  (int_rom_sel),
        .slot_sel     (slot_sel),
        .exp_en       (exp_en),
        .idle_ff      (idle_ff),
        .set_req      (set_req),
        .set_id       (set_id)
    );

    romwin_owner #(.NUM_SLOTS(NUM_SLOTS)) u_owner (
        .clk          (clk),
        .rst          (rst),
        .set_req      (set_req),
        .set_id       (set_id),
        .clr_req      (info.is_clr),
        .card_present (card_present),
        .owner        (owner)
    );
endmodule

// File: rtl/romwin_chk.sv
module romwin_chk
    import romwin_pkg::*;
#(
    parameter int NUM_SLOTS = 7
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 acc_valid,
    input logic [15:0]          acc_addr,
    input logic                 slot_rom_en,
    input logic                 slot3_int,
    input logic [NUM_SLOTS-1:0] card_present,
    input logic                 int_rom_sel,
    input logic [NUM_SLOTS-1:0] slot_sel,
    input logic [NUM_SLOTS-1:0] exp_en,
    input logic                 idle_ff,
    input slot_id_t             owner
);
    logic win_acc;
    logic any_out;
    logic basic_card;
    assign win_acc    = acc_valid && in_window(acc_addr);
    assign any_out    = int_rom_sel || (slot_sel != '0) || (exp_en != '0) || idle_ff;
    assign basic_card = win_acc && slot_rom_en && !acc_addr[11]
                        && !(slot3_int && acc_addr[11:8] == 4'h3);

    // R1
    reset_clears_owner_chk: assert property (@(posedge clk) $fell(rst) |-> owner == '0);

    // R2
    outside_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !win_acc |-> !any_out);

    // R3
    rom_off_internal_chk: assert property (@(posedge clk) disable iff (rst)
        (win_acc && !slot_rom_en) |-> int_rom_sel);

    // R4
    page3_keeps_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (win_acc && slot3_int && acc_addr[11:8] == 4'h3)
        |=> (owner == $past(owner) || owner == '0));

    // R6
    basic_sets_owner_chk: assert property (@(posedge clk) disable iff (rst)
        basic_card |=> owner == slot_id_t'($past(acc_addr[10:8])));

    // R8
    clr_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_addr == 16'hCFFF) |=> owner == '0);

    // R10
    one_source_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({int_rom_sel, slot_sel, exp_en, idle_ff}) == (win_acc ? 1 : 0));
endmodule

bind rom_window_sel romwin_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_valid    (acc_valid),
    .acc_addr     (acc_addr),
    .slot_rom_en  (slot_rom_en),
    .slot3_int    (slot3_int),
    .card_present (card_present),
    .int_rom_sel  (int_rom_sel),
    .slot_sel     (slot_sel),
    .exp_en       (exp_en),
    .idle_ff      (idle_ff),
    .owner        (owner)
);

// File: tb/rom_window_sel_bench.sv
`timescale 1ns/1ps
module rom_window_sel_bench;
    localparam int NS = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_valid = 1'b0;
    logic [15:0]   acc_addr = '0;
    logic          slot_rom_en = 1'b0;
    logic          slot3_int = 1'b0;
    logic [NS-1:0] card_present = '0;
    logic          int_rom_sel;
    logic [NS-1:0] slot_sel;
    logic [NS-1:0] exp_en;
    logic          idle_ff;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    logic [2:0]    m_owner = '0;
    logic [NS-1:0] m_prev = '0;

    always #2.5 clk = ~clk;

    rom_window_sel #(.NUM_SLOTS(NS)) u_rom_window_sel (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .slot_rom_en(slot_rom_en), .slot3_int(slot3_int), .card_present(card_present),
        .int_rom_sel(int_rom_sel), .slot_sel(slot_sel), .exp_en(exp_en), .idle_ff(idle_ff)
    );

    function automatic logic inwin(logic v, logic [15:0] a);
        return v && a[15:12] == 4'hC && a[11:8] != 4'h0;
    endfunction

    function automatic logic cardpath(logic v, logic [15:0] a, logic en, logic o3);
        return inwin(v, a) && en && !(o3 && a[11:8] == 4'h3);
    endfunction

    // expected {int, slot_sel, exp_en, idle}
    function automatic logic [2*NS+1:0] expect_out(logic v, logic [15:0] a, logic en,
                                                   logic o3, logic [NS-1:0] pr, logic [2:0] own);
        logic [NS-1:0] s = '0;
        logic [NS-1:0] e = '0;
        if (!inwin(v, a)) return '0;
        if (!cardpath(v, a, en, o3)) return {1'b1, {(2*NS){1'b0}}, 1'b0};
        if (!a[11]) begin
            if (a[10:8] != 0 && pr[a[10:8]-1]) s[a[10:8]-1] = 1'b1;
        end else begin
            if (own != 0 && pr[own-1]) e[own-1] = 1'b1;
        end
        return {1'b0, s, e, (s == 0 && e == 0)};
    endfunction

    function automatic string tag_of(logic v, logic [15:0] a, logic en, logic o3);
        if (!inwin(v, a)) return "R2";
        if (!en) return "R3";
        if (o3 && a[11:8] == 4'h3) return "R4";
        if (a == 16'hCFFF) return "R8";
        return a[11] ? "R7" : "R5";
    endfunction

    task automatic check(string tag, logic [2*NS+1:0] act, logic [2*NS+1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic acc(logic v, logic [15:0] a, logic en, logic o3,
                       logic [NS-1:0] pr, string tag);
        logic [2*NS+1:0] exp;
        logic [2*NS+1:0] act;
        @(negedge clk);
        acc_valid = v; acc_addr = a; slot_rom_en = en; slot3_int = o3; card_present = pr;
        #1;
        exp = expect_out(v, a, en, o3, pr, m_owner);
        act = {int_rom_sel, slot_sel, exp_en, idle_ff};
        check((tag == "") ? tag_of(v, a, en, o3) : tag, act, exp);
        // R10 exactly one source in window, none outside
        n_checks++;
        if ($countones(act) != (inwin(v, a) ? 1 : 0)) begin
            n_fail++;
            $display("FAIL R10 actual=%0d expected=%0d", $countones(act), inwin(v, a) ? 1 : 0);
        end
        @(posedge clk);
        if (cardpath(v, a, en, o3) && !a[11]) m_owner = a[10:8];
        else if (v && a == 16'hCFFF) m_owner = '0;
        else if (m_owner != 0 && m_prev[m_owner-1] && !pr[m_owner-1]) m_owner = '0;
        m_prev = pr;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] a;
        logic en, o3, v;
        logic [NS-1:0] pr;
        int unsigned seed;
        int unsigned r;
        seed = 32'd1234;
        r = $urandom(seed);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_owner = '0; m_prev = '0;

        // R1 reset: nobody owns the expansion window
        acc(1, 16'hC800, 1, 0, 7'h7F, "R1");
        // R2 outside window and no valid
        acc(1, 16'hC0FF, 1, 0, 7'h7F, "R2");
        acc(1, 16'hD000, 1, 0, 7'h7F, "R2");
        acc(0, 16'hC600, 1, 0, 7'h7F, "R2");
        // R5 basic page select, R6 sets owner, R7 expansion served
        acc(1, 16'hC6A0, 1, 0, 7'h7F, "R5");
        acc(1, 16'hC900, 1, 0, 7'h7F, "R7");
        // R4 override keeps owner 6
        acc(1, 16'hC310, 1, 1, 7'h7F, "R4");
        acc(1, 16'hC800, 1, 1, 7'h7F, "R4");
        // R3 rom disabled: internal, owner kept
        acc(1, 16'hC200, 0, 0, 7'h7F, "R3");
        acc(1, 16'hC801, 1, 0, 7'h7F, "R3");
        // R8 $CFFF served by owner then cleared
        acc(1, 16'hCFFF, 1, 0, 7'h7F, "R8");
        acc(1, 16'hC800, 1, 0, 7'h7F, "R8");
        // R6 empty slot still takes ownership
        acc(1, 16'hC200, 1, 0, 7'h7D, "R6");
        acc(1, 16'hCA00, 1, 0, 7'h7D, "R6");
        acc(1, 16'hCA00, 1, 0, 7'h7F, "R6");
        // R9 removal clears, reinsertion does not restore
        acc(1, 16'hC700, 1, 0, 7'h7F, "R9");
        acc(0, 16'h0000, 1, 0, 7'h3F, "R9");
        acc(1, 16'hC800, 1, 0, 7'h7F, "R9");
        // R8 clear with slot ROM disabled
        acc(1, 16'hC500, 1, 0, 7'h7F, "R8");
        acc(1, 16'hCFFF, 0, 0, 7'h7F, "R8");
        acc(1, 16'hC800, 1, 0, 7'h7F, "R8");

        pr = 7'h7F; en = 1; o3 = 0;
        for (int k = 0; k < 3000; k++) begin
            r = $urandom();
            if (r[3:0] == 0) en = ~en;
            if (r[7:4] == 0) o3 = ~o3;
            if (r[11:8] == 0) pr = pr ^ (7'd1 << (r[14:12] % 7));
            v = (r[17:15] != 0);
            case (r[20:18])
                3'd0:    a = 16'hCFFF;
                3'd1:    a = $urandom();
                default: a = {4'hC, $urandom_range(15, 0) > 0 ? 4'($urandom_range(15, 1)) : 4'h0,
                              8'($urandom())};
            endcase
            acc(v, a, en, o3, pr, "");
        end
        finish_run();
    end
endmodule